// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects a set of level-sensitive interrupt request lines and routes them to several processor targets. Every source has a shared priority register. Every target has its own enable bit array, its own priority threshold and its own claim/complete register, and it drives one interrupt output. A target's handler reads its claim/complete register to receive the identifier of the best waiting source, which also takes that source out of the waiting set. When the service is finished, the handler writes the same identifier back to the register.

Each source is guarded by a gateway state machine with three states. `GW_IDLE` means no request is held. `GW_PEND` means a request is latched and waiting. `GW_BUSY` means a target has claimed the request and it is in service. The gateway moves between them as follows:

- `GW_IDLE` to `GW_PEND` when the request line is high.
- `GW_PEND` to `GW_BUSY` when a claim returns this source.
- `GW_BUSY` to `GW_IDLE` when a completion names this source.

Each target has an arbiter that scans the pending sources on every cycle and registers the target's interrupt output.

The register bus uses word addresses. Bits [11:10] select a region and bits [9:0] form an index within it. A read returns its data one cycle after the read strobe.

Top module: `intc_core`

## Requirements
- R1: The priority register of source `s` is at word address `s` (region 0). It is shared by all targets. The threshold of target `t` is at `0x800 + 2t`. Both read back the value written (PRIO_W bits, zero-extended), with read data valid the cycle after the read strobe.
- R2: The enable bits of target `t` are packed 32 per word at `0x400 + 32t + w`. Source `s` is word `s/32`, bit `s%32`. Each target has `(NUM_SRC+32)/32` words. Bits that map to no existing source read back as 0.
- R3: Identifier 0 is reserved. Its enable bit always reads 0, a priority write to address 0 is ignored, and that address reads 0.
- R4: A gateway latches a high request level as pending. After a claim, the source stays out of the pending set until a completion for it arrives, even if its line stays high. A completion for a source that is not in service is ignored.
- R5: A read of the claim/complete register at `0x801 + 2t` returns the eligible source with the highest priority, the lowest identifier winning a tie. It returns 0 when no source is eligible.
- R6: A claim read that returns a nonzero identifier clears that source's pending state at the same clock edge.
- R7: A source is eligible for a target only if it is pending, enabled for that target, and has a priority strictly above that target's threshold. Priority 0 therefore never interrupts.
- R8: Each interrupt output is registered. It reflects a change of pending state, enable, priority or threshold one clock after the edge that made the change.
- R9: After a claim, the output stays high while another eligible source is still pending.
- R10: Targets are independent: enable arrays, thresholds, claims and outputs of one target do not affect another.
- R11: A completion written while the source's line is still high returns the gateway to idle, and the source pends again on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC (indices NUM_SRC:1) | Level request of each source, bit index equals source identifier |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a claim read has a side effect) |
| bus_addr | input | 12 | Word address: bits [11:10] region, bits [9:0] index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, zero otherwise |
| tgt_eip | output | NUM_TGT | Registered interrupt output per target |

## Verification
The hardest case to reach from the ports is a source that must stay out of the pending set while it is in service, with its line still high. A completion aimed at a source that is merely pending is a related hard case. The stimulus claims a source, holds its line high, and shows that a second claim returns 0. It then latches a different source with a short pulse and sends a stray completion for it, after which a claim must still return that source. Completing the held source then has to re-pend it. The table of vectors covers threshold boundaries, priority ties and sources in the second enable word. Directed tests cover the one-cycle output lag and cross-target isolation.

// File: rtl/intc_core_pkg.sv
package intc_core_pkg;

    localparam int BUS_AW = 12;

    localparam logic [1:0] RGN_PRIO = 2'd0;
    localparam logic [1:0] RGN_EN   = 2'd1;
    localparam logic [1:0] RGN_TGT  = 2'd2;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

endpackage

// File: rtl/intc_gateway.sv
module intc_gateway
    import intc_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_lvl,
    input  logic claim_hit,
    input  logic done_hit,
    output logic pending
);

    gw_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (irq_lvl)   state_d = GW_PEND;
            GW_PEND: if (claim_hit) state_d = GW_BUSY;
            GW_BUSY: if (done_hit)  state_d = GW_IDLE;
            default:                state_d = GW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q == GW_PEND);
    end

endmodule

// File: rtl/intc_target_arb.sv
module intc_target_arb #(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC:1]               pend,
    input  logic [NUM_SRC:1]               en,
    input  logic [NUM_SRC:1][PRIO_W-1:0]   prio,
    input  logic [PRIO_W-1:0]              thresh,
    output logic [ID_W-1:0]                best_id,
    output logic                           eip
);

    logic [PRIO_W-1:0] run_prio;

    // ascending scan with strict compare: ties keep the lower identifier
    always_comb begin
        run_prio = thresh;
        best_id  = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > run_prio)) begin
                run_prio = prio[i];
                best_id  = ID_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eip <= 1'b0;
        else        eip <= |best_id;
    end

endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_core_pkg::*;
#(
    parameter int NUM_SRC = 35,
    parameter int NUM_TGT = 2,
    parameter int PRIO_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     src_irq,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_TGT-1:0]   tgt_eip
);

    localparam int EN_WORDS = (NUM_SRC + 32) / 32;
    localparam int EN_BITS  = EN_WORDS * 32;
    localparam int ID_W     = $clog2(NUM_SRC + 1);

    function automatic logic [EN_BITS-1:0] en_mask_f();
        logic [EN_BITS-1:0] m;
        m = '0;
        for (int i = 1; i <= NUM_SRC; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [EN_BITS-1:0] EN_MASK = en_mask_f();

    // register state
    logic [NUM_SRC:1][PRIO_W-1:0]      prio_q;
    logic [NUM_TGT-1:0][EN_BITS-1:0]   en_q;
    logic [NUM_TGT-1:0][PRIO_W-1:0]    thr_q;

    // address split
    logic [1:0] region;
    logic [9:0] idx;
    assign region = bus_addr[11:10];
    assign idx    = bus_addr[9:0];

    // gateways
    logic [NUM_SRC:1] pend;
    logic [NUM_SRC:1] claim_hit;
    logic [NUM_SRC:1] done_hit;

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
        intc_gateway u_gw (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_lvl   (src_irq[g]),
            .claim_hit (claim_hit[g]),
            .done_hit  (done_hit[g]),
            .pending   (pend[g])
        );
    end

    // per-target arbitration
    logic [NUM_TGT-1:0][ID_W-1:0] best_id;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        intc_target_arb #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend    (pend),
            .en      (en_q[t][NUM_SRC:1]),
            .prio    (prio_q),
            .thresh  (thr_q[t]),
            .best_id (best_id[t]),
            .eip     (tgt_eip[t])
        );
    end

    // read mux and claim/complete decode
    logic            claim_go;
    logic            done_go;
    logic [ID_W-1:0] claim_id;
    logic [31:0]     rd_mux;

    always_comb begin
        claim_go = 1'b0;
        done_go  = 1'b0;
        claim_id = '0;
        rd_mux   = '0;
        unique case (region)
            RGN_PRIO: begin
                for (int i = 1; i <= NUM_SRC; i++)
                    if (int'(idx) == i) rd_mux = 32'(prio_q[i]);
            end
            RGN_EN: begin
                for (int t = 0; t < NUM_TGT; t++)
                    for (int w = 0; w < EN_WORDS; w++)
                        if (int'(idx[9:5]) == t && int'(idx[4:0]) == w)
                            rd_mux = en_q[t][w*32 +: 32];
            end
            RGN_TGT: begin
                for (int t = 0; t < NUM_TGT; t++) begin
                    if (int'(idx[9:1]) == t) begin
                        if (idx[0]) begin
                            claim_go = bus_rd;
                            done_go  = bus_wr;
                            claim_id = best_id[t];
                            rd_mux   = 32'(best_id[t]);
                        end else begin
                            rd_mux   = 32'(thr_q[t]);
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int i = 1; i <= NUM_SRC; i++) begin
            claim_hit[i] = claim_go && (int'(claim_id) == i);
            done_hit[i]  = done_go && (bus_wdata == 32'(i));
        end
    end

    // register writes and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q    <= '0;
            en_q      <= '0;
            thr_q     <= '0;
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
            if (bus_wr) begin
                unique case (region)
                    RGN_PRIO: begin
                        for (int i = 1; i <= NUM_SRC; i++)
                            if (int'(idx) == i) prio_q[i] <= bus_wdata[PRIO_W-1:0];
                    end
                    RGN_EN: begin
                        for (int t = 0; t < NUM_TGT; t++)
                            for (int w = 0; w < EN_WORDS; w++)
                                if (int'(idx[9:5]) == t && int'(idx[4:0]) == w)
                                    en_q[t][w*32 +: 32] <= bus_wdata & EN_MASK[w*32 +: 32];
                    end
                    RGN_TGT: begin
                        for (int t = 0; t < NUM_TGT; t++)
                            if (int'(idx[9:1]) == t && !idx[0])
                                thr_q[t] <= bus_wdata[PRIO_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
    parameter int NUM_SRC = 35,
    parameter int ID_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_SRC:1] src_irq,
    input logic [NUM_SRC:1] pend,
    input logic [NUM_SRC:1] claim_hit,
    input logic [NUM_SRC:1] done_hit,
    input logic             claim_go,
    input logic [ID_W-1:0]  claim_id
);

    logic [NUM_SRC:0] pend_ext;
    assign pend_ext = {pend, 1'b0};

    // R6
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_hit) |=> ((pend & $past(claim_hit)) == '0));

    // R4
    pend_needs_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(src_irq)) == '0));

    // R5
    claim_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && (claim_id != '0)) |-> pend_ext[claim_id]);

    // R6
    claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_hit));

    // R4
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_hit));

endmodule

bind intc_core intc_core_chk #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_irq   (src_irq),
    .pend      (pend),
    .claim_hit (claim_hit),
    .done_hit  (done_hit),
    .claim_go  (claim_go),
    .claim_id  (claim_id)
);

// File: tb/intc_core_tb_top.sv
module intc_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 35;
    localparam int NTGT = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   src_irq = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NTGT-1:0] tgt_eip;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_core #(.NUM_SRC(NSRC), .NUM_TGT(NTGT), .PRIO_W(3)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tgt_eip   (tgt_eip)
    );

    function automatic logic [NSRC:1] ib(int id);
        logic [NSRC:1] r;
        r = '0;
        r[id] = 1'b1;
        return r;
    endfunction

    typedef struct packed {
        logic [NSRC:1] mask;
        logic [2:0]    thr;
        logic [5:0]    exp_id;
    } vec_t;

    // priority of source i is (i % 7) + 1
    localparam vec_t VECS [9] = '{
        '{ib(1) | ib(2) | ib(3),   3'd0, 6'd3 },
        '{ib(6) | ib(13),          3'd0, 6'd6 },
        '{ib(6) | ib(13),          3'd7, 6'd0 },
        '{ib(5) | ib(12),          3'd5, 6'd5 },
        '{ib(33) | ib(34),         3'd0, 6'd34},
        '{ib(7) | ib(14) | ib(35), 3'd0, 6'd7 },
        '{ib(7) | ib(14) | ib(35), 3'd1, 6'd0 },
        '{'0,                      3'd0, 6'd0 },
        '{ib(2) | ib(20),          3'd3, 6'd20}
    };

    function automatic logic [11:0] a_prio(int id);  return 12'(id); endfunction
    function automatic logic [11:0] a_en(int t, int w); return 12'h400 + 12'(t*32 + w); endfunction
    function automatic logic [11:0] a_thr(int t);    return 12'h800 + 12'(2*t); endfunction
    function automatic logic [11:0] a_clm(int t);    return 12'h801 + 12'(2*t); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drain(input int t);
        logic [31:0] id;
        bus_write(a_thr(t), 0);
        for (int k = 0; k < 64; k++) begin
            bus_read(a_clm(t), id);
            if (id == 0) break;
            bus_write(a_clm(t), id);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        check("R8 reset eip", 32'(tgt_eip), 0);
        bus_read(a_clm(0), got);  check("R5 reset claim", got, 0);
        bus_read(a_prio(5), got); check("R1 reset prio", got, 0);
        bus_read(a_en(0, 0), got); check("R2 reset enable", got, 0);

        // register setup and readback
        for (int i = 1; i <= NSRC; i++) bus_write(a_prio(i), (i % 7) + 1);
        bus_read(a_prio(9), got); check("R1 prio readback", got, 3);
        bus_write(a_prio(0), 7);
        bus_read(a_prio(0), got); check("R3 prio id0 ignored", got, 0);
        bus_write(a_en(0, 0), 32'hFFFF_FFFF);
        bus_write(a_en(0, 1), 32'hFFFF_FFFF);
        bus_read(a_en(0, 0), got); check("R3 enable bit0 reads 0", got, 32'hFFFF_FFFE);
        bus_read(a_en(0, 1), got); check("R2 enable word1 packing", got, 32'h0000_000F);
        bus_read(a_en(1, 0), got); check("R10 target1 enable untouched", got, 0);
        bus_write(a_thr(1), 5);
        bus_read(a_thr(1), got); check("R1 threshold readback", got, 5);
        bus_read(a_thr(0), got); check("R10 target0 threshold untouched", got, 0);
        bus_write(a_thr(1), 0);

        // vector table: R5 R7 R2
        for (int v = 0; v < 9; v++) begin
            bus_write(a_thr(0), 32'(VECS[v].thr));
            src_irq = VECS[v].mask;
            idle(2);
            check($sformatf("R7 vec%0d eip", v), 32'(tgt_eip[0]), 32'(VECS[v].exp_id != 0));
            bus_read(a_clm(0), got);
            check($sformatf("R5 vec%0d claim", v), got, 32'(VECS[v].exp_id));
            src_irq = '0;
            if (got != 0) bus_write(a_clm(0), got);
            drain(0);
        end

        // R4 in-service source blocked, stray completion ignored; R11 re-arm
        src_irq = ib(4);
        idle(2);
        bus_read(a_clm(0), got); check("R6 claim source 4", got, 4);
        idle(1);
        check("R4 eip low while in service", 32'(tgt_eip[0]), 0);
        bus_read(a_clm(0), got); check("R4 no re-pend before complete", got, 0);
        src_irq = ib(4) | ib(3);
        idle(2);
        src_irq = ib(4);
        bus_write(a_clm(0), 3);
        idle(1);
        bus_read(a_clm(0), got); check("R4 complete of pending id ignored", got, 3);
        bus_write(a_clm(0), 3);
        bus_write(a_clm(0), 4);
        idle(2);
        check("R11 eip after re-arm", 32'(tgt_eip[0]), 1);
        bus_read(a_clm(0), got); check("R11 re-pend after complete", got, 4);
        src_irq = '0;
        bus_write(a_clm(0), 4);
        drain(0);

        // R9 line stays high with lower-priority pending
        src_irq = ib(20) | ib(2);
        idle(2);
        bus_read(a_clm(0), got); check("R5 first claim highest", got, 20);
        idle(1);
        check("R9 eip held after claim", 32'(tgt_eip[0]), 1);
        bus_read(a_clm(0), got); check("R9 second claim", got, 2);
        idle(1);
        check("R9 eip drops when empty", 32'(tgt_eip[0]), 0);
        bus_read(a_clm(0), got); check("R5 repeated claim zero", got, 0);
        src_irq = '0;
        bus_write(a_clm(0), 20);
        bus_write(a_clm(0), 2);
        drain(0);

        // R10 independent targets
        bus_write(a_en(0, 0), 32'(1) << 20);
        bus_write(a_en(0, 1), 0);
        bus_write(a_en(1, 0), 32'(1) << 8);
        src_irq = ib(8) | ib(20);
        idle(2);
        check("R10 both eip", 32'(tgt_eip), 3);
        bus_write(a_thr(0), 7);
        idle(1);
        check("R10 threshold per target", 32'(tgt_eip), 2);
        bus_write(a_thr(0), 0);
        bus_read(a_clm(1), got); check("R10 target1 claim", got, 8);
        bus_read(a_clm(0), got); check("R10 target0 claim", got, 20);
        src_irq = '0;
        bus_write(a_clm(1), 8);
        bus_write(a_clm(0), 20);
        drain(0);
        drain(1);

        // R7 priority zero never interrupts; R8 one-cycle lag
        bus_write(a_en(0, 0), 32'hFFFF_FFFF);
        bus_write(a_prio(10), 0);
        src_irq = ib(10);
        idle(2);
        check("R7 prio0 no eip", 32'(tgt_eip[0]), 0);
        bus_read(a_clm(0), got); check("R7 prio0 claim zero", got, 0);
        bus_write(a_prio(10), 1);
        check("R8 eip not yet updated", 32'(tgt_eip[0]), 0);
        idle(1);
        check("R8 eip one cycle later", 32'(tgt_eip[0]), 1);
        bus_read(a_clm(0), got); check("R5 claim after prio raise", got, 10);
        src_irq = '0;
        bus_write(a_clm(0), 10);
        drain(0);

        finish_run();
    end

endmodule